// File: doc/BRIEF.md
# Card Bus Transfer Sequencer

This block is the command and data path of a host controller for a removable-card serial bus. Software reaches it through a small register port. From there it sets the FIFO direction and a clock-divider value, moves data through an 8-byte FIFO as 32-bit words, and writes a command word. The command word carries an 8-bit protocol code and a byte count. Bit 3 of the code selects the direction: a write to the card or a read from it. The direction from the code replaces the software direction bit at the moment the protocol starts.

On the card side, the serial bit timing is reduced to byte handshakes. Write-direction bytes leave on a valid/ready pair (`out_*`), and read-direction bytes arrive on another (`in_*`). While a protocol is active, `drq` asks software for FIFO service. The block pulses `proto_end` when the requested number of bytes has crossed the bus.

A soft reset clears all state except the clock divider, and it clears itself after one cycle. It aborts any protocol in flight.

Top module: `card_xfer_seq`

Register map (2-bit address):
- 0 (SYS): bit 0 FIFO direction (1 = toward card), bit 1 soft reset, bits 15:8 clock divider.
- 1 (DATA): a write pushes a word and a read pops a word. Byte 0 is bits 7:0 and is the oldest byte.
- 2 (CMD): bits 7:0 code, bits 25:16 byte count.
- 3 (STAT): bit 0 FIFO empty, bit 1 FIFO full, bit 2 busy, bit 3 `drq`.

## Requirements
- R1: After `rst_n`, STAT reads 0x1 (empty, not busy, no request) and SYS reads 0.
- R2: Writing SYS with bit 1 set starts a soft reset. SYS bit 1 reads 1 in the following cycle and 0 one cycle later. The reset empties the FIFO, clears the direction bit, aborts an active protocol without a `proto_end` pulse, and stops the card handshakes.
- R3: A soft reset leaves SYS bits 15:8 unchanged. A SYS write with bit 1 set changes no other field.
- R4: A CMD write starts a protocol (busy = 1) only when the block is idle and the count is nonzero. Any other CMD write is ignored.
- R5: At protocol start, SYS bit 0 takes the value of code bit 3, whatever software wrote before.
- R6: In a write protocol, exactly `count` bytes leave on `out_byte`, in FIFO order, with byte 0 of each pushed word first.
- R7: `drq` is 1 only while busy: in a write protocol when the FIFO is empty, in a read protocol when the FIFO is full.
- R8: `proto_end` is high for exactly one cycle, in the cycle after the final byte handshake, and busy is 0 in that cycle.
- R9: When a write protocol ends, any leftover FIFO bytes are discarded and STAT shows empty.
- R10: When a read protocol ends, the last partial 8-byte group is padded so that STAT shows full. Its first (count mod 8) bytes hold the received data.
- R11: A word push is ignored when the FIFO holds more than 4 bytes. A word pop is ignored when it holds fewer than 4 bytes. Neither disturbs the stored order.
- R12: `out_valid` is 1 only in an active write protocol with a non-empty FIFO. `in_ready` is 1 only in an active read protocol with a FIFO that is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at DATA) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on address |
| drq | output | 1 | FIFO service request |
| busy | output | 1 | Protocol active |
| proto_end | output | 1 | One-cycle end-of-protocol pulse |
| out_valid | output | 1 | Byte toward card is valid |
| out_byte | output | 8 | Byte toward card |
| out_ready | input | 1 | Card accepts the byte |
| in_valid | input | 1 | Card offers a byte |
| in_byte | input | 8 | Byte from card |
| in_ready | output | 1 | Block accepts the byte |

## Verification
The bench targets byte counts that are not multiples of 8, checking both sides of each partial group:
- In a write, a block that fails to stop or flush would send padding bytes to the card or leave the FIFO non-empty.
- In a read, a block that fails to pad would never show full, and software would have nothing to drain.

A command issued against the opposite software direction exposes a block that ignores code bit 3, since its SYS readback stays stale. A soft reset in mid-write catches three faults:
- a stray `proto_end` pulse;
- a clock divider wiped along with everything else;
- a reset bit that never clears.

Pushes into a FIFO that is too full, and pops from an empty one, reveal pointer corruption when later words come back out of order.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    A_SYS  = 2'd0,
    A_DATA = 2'd1,
    A_CMD  = 2'd2,
    A_STAT = 2'd3
  } reg_sel_e;

  // Direction carried by the protocol code: 1 = toward the card.
  function automatic logic f_code_dir(input logic [7:0] code);
    return code[3];
  endfunction

  // Service request: writer wants the FIFO refilled, reader wants it drained.
  function automatic logic f_drq(input logic active, input logic to_card,
                                 input logic empty, input logic full);
    return active & (to_card ? empty : full);
  endfunction

  // Byte occupancy after one cycle of word/byte traffic.
  function automatic int unsigned f_level_next(input int unsigned lvl,
                                               input logic wpush, input logic wpop,
                                               input logic bpush, input logic bpop);
    int unsigned n;
    n = lvl;
    if (wpush) n = n + WORD_BYTES;
    if (bpush) n = n + 1;
    if (wpop)  n = n - WORD_BYTES;
    if (bpop)  n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/card_byte_fifo.sv
module card_byte_fifo
  import card_seq_pkg::*;
#(
  parameter int unsigned WORDS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clear,
  input  logic                            flush,
  input  logic                            pad,
  input  logic                            word_push,
  input  logic [31:0]                     word_in,
  input  logic                            word_pop,
  input  logic                            byte_push,
  input  logic [7:0]                      byte_in,
  input  logic                            byte_pop,
  output logic [31:0]                     word_out,
  output logic [7:0]                      byte_out,
  output logic [$clog2(WORDS*4+1)-1:0]    level,
  output logic                            empty,
  output logic                            full
);
  localparam int unsigned DEPTH = WORDS * WORD_BYTES;
  localparam int unsigned PW    = $clog2(DEPTH);
  localparam int unsigned LW    = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rptr, wptr, rptr_n, wptr_n;

  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign byte_out = mem[rptr];

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign word_out[8*k +: 8] = mem[rptr + PW'(k)];
  end

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    if (word_push) wptr_n = wptr + PW'(WORD_BYTES);
    else if (byte_push) wptr_n = wptr + PW'(1);
    if (word_pop) rptr_n = rptr + PW'(WORD_BYTES);
    else if (byte_pop) rptr_n = rptr + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (word_push) begin
      for (int k = 0; k < WORD_BYTES; k++) mem[wptr + PW'(k)] <= word_in[8*k +: 8];
    end else if (byte_push) begin
      mem[wptr] <= byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      level <= '0;
    end else if (clear) begin
      rptr  <= '0;
      wptr  <= '0;
      level <= '0;
    end else if (flush) begin
      rptr  <= wptr_n;
      wptr  <= wptr_n;
      level <= '0;
    end else if (pad) begin
      rptr  <= rptr_n;
      wptr  <= rptr_n;
      level <= LW'(DEPTH);
    end else begin
      rptr  <= rptr_n;
      wptr  <= wptr_n;
      level <= LW'(f_level_next(int'(level), word_push, word_pop, byte_push, byte_pop));
    end
  end

  p_level_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  p_pad_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad && !clear) |=> full);
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !clear) |=> empty);

endmodule

// File: rtl/card_proto_fsm.sv
module card_proto_fsm #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic             start_dir,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             beat,
  output logic             active,
  output logic             dir,
  output logic             last_beat,
  output logic             end_pulse
);
  logic [CNT_W-1:0] remaining;

  assign last_beat = active & beat & (remaining == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      dir       <= 1'b0;
      remaining <= '0;
      end_pulse <= 1'b0;
    end else if (abort) begin
      active    <= 1'b0;
      remaining <= '0;
      end_pulse <= 1'b0;
    end else begin
      end_pulse <= last_beat;
      if (start) begin
        active    <= 1'b1;
        dir       <= start_dir;
        remaining <= start_cnt;
      end else if (active && beat) begin
        remaining <= remaining - CNT_W'(1);
        if (remaining == CNT_W'(1)) active <= 1'b0;
      end
    end
  end

  p_end_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> !end_pulse);
  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> !active);
  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
  p_hold_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !beat && !abort && !start) |=> $stable(remaining));

endmodule

// File: rtl/card_xfer_seq.sv
module card_xfer_seq
  import card_seq_pkg::*;
#(
  parameter int unsigned FIFO_WORDS = 2,
  parameter int unsigned CNT_W      = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        drq,
  output logic        busy,
  output logic        proto_end,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  input  logic        out_ready,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready
);
  localparam int unsigned DEPTH = FIFO_WORDS * WORD_BYTES;
  localparam int unsigned LW    = $clog2(DEPTH + 1);
  localparam int unsigned CNT_LSB = 16;

  logic             srst, fdir;
  logic [7:0]       clkdiv;
  logic [7:0]       cmd_code;
  logic [CNT_W-1:0] cmd_cnt;

  logic wr_sys, wr_data, wr_cmd, rd_data;
  logic tx_beat, rx_beat, start, last_beat, dir;
  logic word_push, word_pop, empty, full;
  logic [LW-1:0] level;
  logic [31:0]   word_out;
  logic [7:0]    fifo_byte;
  logic [CNT_W-1:0] new_cnt;

  assign wr_sys  = reg_wr & (reg_sel_e'(reg_addr) == A_SYS);
  assign wr_data = reg_wr & (reg_sel_e'(reg_addr) == A_DATA);
  assign wr_cmd  = reg_wr & (reg_sel_e'(reg_addr) == A_CMD);
  assign rd_data = reg_rd & (reg_sel_e'(reg_addr) == A_DATA);
  assign new_cnt = reg_wdata[CNT_LSB +: CNT_W];

  assign out_valid = busy & dir & ~empty;
  assign out_byte  = fifo_byte;
  assign in_ready  = busy & ~dir & ~full;
  assign tx_beat   = out_valid & out_ready;
  assign rx_beat   = in_valid & in_ready;

  assign word_push = wr_data & ~srst & ~rx_beat & (level <= LW'(DEPTH - WORD_BYTES));
  assign word_pop  = rd_data & ~srst & ~tx_beat & (level >= LW'(WORD_BYTES));
  assign start     = wr_cmd & ~srst & ~busy & (new_cnt != '0);
  assign drq       = f_drq(busy, dir, empty, full);

  card_byte_fifo #(.WORDS(FIFO_WORDS)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (srst),
    .flush     (last_beat & dir),
    .pad       (last_beat & ~dir),
    .word_push (word_push),
    .word_in   (reg_wdata),
    .word_pop  (word_pop),
    .byte_push (rx_beat),
    .byte_in   (in_byte),
    .byte_pop  (tx_beat),
    .word_out  (word_out),
    .byte_out  (fifo_byte),
    .level     (level),
    .empty     (empty),
    .full      (full)
  );

  card_proto_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (srst),
    .start     (start),
    .start_dir (f_code_dir(reg_wdata[7:0])),
    .start_cnt (new_cnt),
    .beat      (tx_beat | rx_beat),
    .active    (busy),
    .dir       (dir),
    .last_beat (last_beat),
    .end_pulse (proto_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst     <= 1'b0;
      fdir     <= 1'b0;
      clkdiv   <= '0;
      cmd_code <= '0;
      cmd_cnt  <= '0;
    end else if (srst) begin
      srst     <= 1'b0;
      fdir     <= 1'b0;
      cmd_code <= '0;
      cmd_cnt  <= '0;
    end else begin
      if (start) begin
        fdir     <= f_code_dir(reg_wdata[7:0]);
        cmd_code <= reg_wdata[7:0];
        cmd_cnt  <= new_cnt;
      end else if (wr_sys) begin
        if (reg_wdata[1]) begin
          srst <= 1'b1;
        end else begin
          fdir   <= reg_wdata[0];
          clkdiv <= reg_wdata[15:8];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      A_SYS:  reg_rdata = {16'b0, clkdiv, 6'b0, srst, fdir};
      A_DATA: reg_rdata = word_out;
      A_CMD:  begin
        reg_rdata[7:0] = cmd_code;
        reg_rdata[CNT_LSB +: CNT_W] = cmd_cnt;
      end
      A_STAT: reg_rdata = {28'b0, drq, busy, full, empty};
    endcase
  end

  p_drq_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> busy);
  p_tx_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy && !empty));
  p_rx_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !full));
  p_srst_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);
  p_clkdiv_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> $stable(clkdiv));
  p_fdir_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (fdir == $past(reg_wdata[3])));

endmodule

// File: tb/test_card_xfer_seq.sv
`timescale 1ns/1ps
module test_card_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        drq, busy, proto_end, out_valid, out_ready, in_valid, in_ready;
  logic [7:0]  out_byte, in_byte;

  int vectors = 0, fails = 0, cyc = 0, beats = 0, exp_len = 0;
  bit end_due = 0, rx_pend = 0, card_hold = 0;
  logic [7:0] exp_q[$];
  logic [7:0] src_q[$];

  localparam logic [1:0] SYS = 2'd0, DAT = 2'd1, CMD = 2'd2, STA = 2'd3;

  always #2.5 clk = ~clk;

  card_xfer_seq i_card_xfer_seq (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Card model and scoreboard monitor, all sampled at the falling edge.
  initial begin
    out_ready = 1'b0; in_valid = 1'b0; in_byte = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (end_due) begin
        chk(proto_end && !busy, "R8 end pulse", {30'b0, busy, proto_end}, 32'h1);
        end_due = 0;
      end else if (proto_end) begin
        chk(1'b0, "R8 unexpected end", 32'h1, 32'h0);
      end
      out_ready = !card_hold && (cyc % 3 != 0);
      if (out_valid && out_ready) begin
        beats++;
        if (exp_q.size() == 0) chk(1'b0, "R6 extra byte", {24'b0, out_byte}, 32'h0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_byte == e, "R6 byte order", {24'b0, out_byte}, {24'b0, e});
        end
        if (exp_len != 0 && beats == exp_len) end_due = 1;
      end
      if (rx_pend) void'(src_q.pop_front());
      in_valid = (src_q.size() > 0);
      in_byte  = in_valid ? src_q[0] : 8'h00;
      rx_pend  = in_valid && in_ready;
      if (rx_pend) begin
        beats++;
        if (exp_len != 0 && beats == exp_len) end_due = 1;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit pop, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = pop;
    #0.5 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] wd(input logic [7:0] b0);
    return {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0};
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(STA, 0, v); chk(v == 32'h1, "R1 status", v, 32'h1);
    rd(SYS, 0, v); chk(v == 32'h0, "R1 sys", v, 32'h0);
    chk(!out_valid && !in_ready, "R12 idle handshakes", {30'b0, out_valid, in_ready}, 32'h0);

    // R2/R3: soft reset keeps divider, clears FIFO and direction
    wr(SYS, 32'h5A01);
    wr(DAT, 32'h11223344);
    rd(STA, 0, v); chk(v[0] == 1'b0, "R2 fifo loaded", v, 32'h0);
    wr(SYS, 32'h0002);
    #0.5 chk(reg_rdata[1] == 1'b1, "R2 rst visible", reg_rdata, 32'h5A03);
    rd(SYS, 0, v); chk(v == 32'h5A00, "R3 divider kept, R2 rst cleared", v, 32'h5A00);
    rd(STA, 0, v); chk(v == 32'h1, "R2 fifo empty", v, 32'h1);

    // R4: zero count is ignored
    wr(CMD, 32'h0000_000D);
    rd(STA, 0, v); chk(v[2] == 1'b0, "R4 zero count", v, 32'h1);

    // Write protocol of 11 bytes against software direction 0
    wr(SYS, 32'h0);
    for (int i = 0; i < 11; i++) exp_q.push_back(8'h30 + 8'(i));
    beats = 0; exp_len = 11;
    wr(CMD, (32'd11 << 16) | 32'h0D);
    rd(SYS, 0, v); chk(v[0] == 1'b1, "R5 dir from code", v, 32'h1);
    rd(STA, 0, v); chk(v[3:2] == 2'b11, "R7 drq on empty write, R4 busy", v, 32'hD);
    wr(DAT, wd(8'h30));
    wr(DAT, wd(8'h34));
    wr(CMD, (32'd5 << 16) | 32'h05);
    while (!drq && busy) @(negedge clk);
    chk(drq && out_valid == 1'b0, "R7 drq on refill", {30'b0, drq, out_valid}, 32'h2);
    wr(DAT, wd(8'h38));
    wr(DAT, wd(8'h3C));
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(beats == 11 && exp_q.size() == 0, "R6 byte count, R4 busy cmd ignored", beats, 11);
    rd(STA, 0, v); chk(v == 32'h1, "R9 flushed", v, 32'h1);

    // Read protocol of 13 bytes against software direction 1
    wr(SYS, 32'h1);
    beats = 0; exp_len = 13;
    for (int i = 0; i < 13; i++) src_q.push_back(8'hA0 + 8'(i));
    wr(CMD, (32'd13 << 16) | 32'h05);
    rd(SYS, 0, v); chk(v[0] == 1'b0, "R5 dir from code", v, 32'h0);
    while (!drq && busy) @(negedge clk);
    chk(!in_ready, "R12 full blocks card", {31'b0, in_ready}, 32'h0);
    rd(STA, 0, v); chk(v == 32'hE, "R7 drq on full read", v, 32'hE);
    rd(DAT, 1, v); chk(v == wd(8'hA0), "R10 read word0", v, wd(8'hA0));
    rd(DAT, 1, v); chk(v == wd(8'hA4), "R10 read word1", v, wd(8'hA4));
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(STA, 0, v); chk(v == 32'h2, "R10 padded full", v, 32'h2);
    rd(DAT, 1, v); chk(v == wd(8'hA8), "R10 tail word", v, wd(8'hA8));
    rd(DAT, 1, v); chk(v[7:0] == 8'hAC, "R10 tail byte", v, 32'hAC);
    rd(STA, 0, v); chk(v == 32'h1, "R10 drained", v, 32'h1);

    // R11: push beyond capacity and pop from empty
    wr(SYS, 32'h1);
    wr(DAT, 32'h01020304); wr(DAT, 32'h05060708); wr(DAT, 32'hDEADBEEF);
    rd(STA, 0, v); chk(v == 32'h2, "R11 full", v, 32'h2);
    rd(DAT, 1, v); chk(v == 32'h01020304, "R11 word0", v, 32'h01020304);
    rd(DAT, 1, v); chk(v == 32'h05060708, "R11 word1 not overwritten", v, 32'h05060708);
    rd(DAT, 1, v);
    rd(STA, 0, v); chk(v == 32'h1, "R11 empty pop ignored", v, 32'h1);
    wr(DAT, 32'hCAFEF00D);
    rd(DAT, 1, v); chk(v == 32'hCAFEF00D, "R11 order kept", v, 32'hCAFEF00D);

    // R2: abort a write protocol mid-flight
    wr(SYS, 32'h0);
    for (int i = 0; i < 8; i++) exp_q.push_back(8'h50 + 8'(i));
    beats = 0; exp_len = 0;
    wr(CMD, (32'd20 << 16) | 32'h0D);
    wr(DAT, wd(8'h50));
    wr(DAT, wd(8'h54));
    card_hold = 1;
    @(negedge clk);
    wr(SYS, 32'h2);
    exp_q.delete();
    repeat (2) @(negedge clk);
    rd(STA, 0, v); chk(v == 32'h1, "R2 abort idle and empty", v, 32'h1);
    rd(SYS, 0, v); chk(v == 32'h0, "R2 rst and dir clear", v, 32'h0);
    card_hold = 0;
    repeat (4) @(negedge clk);
    chk(!out_valid && !busy, "R2 no traffic after abort", {30'b0, out_valid, busy}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule